// File: doc/BRIEF.md
# Cartridge Bank Translator

This block is the bank-switching logic of a cartridge that sits on an 8-bit CPU bus and a separate video bus. The CPU programs bank numbers by writing into an expansion register window. The block uses those numbers to turn CPU reads in the 32 KB program window into program-ROM addresses, and video fetches below 0x2000 into pattern-ROM addresses. It also holds a two-bit nametable mirroring mode for the video side.

There are four 8 KB program slots and eight 1 KB pattern slots. Static configuration inputs give the program-ROM size, the pattern-ROM size, whether the pattern memory is a RAM, and the mirroring mode in force before software selects one. Translation is purely combinational from the current register contents. Register writes land on the rising clock edge. The caller qualifies program reads with CPU address bit 15, because the block translates `cpu_addr[14:0]` on every cycle.

Top module: `cart_bank_xlat`

## Requirements
- R1: A write is decoded only when `cpu_addr` lies in 0x4020..0x5FFF. Inside that range only `cpu_addr[10:0]` selects the register, so 0x4504, 0x4D04 and 0x5504 all reach the same register. Writes outside the range change nothing.
- R2: After reset the program slots 0..3 hold banks 0x00, 0x01, 0xFE and 0xFF. All eight pattern slots hold 0. `mirror_mode` equals `cfg_mirror_init` until the first mirroring write.
- R3: A write to offset 0x2FE or 0x2FF sets `mirror_mode` to {`cpu_addr[0]`, `cpu_data[4]`}. The encodings are: 0 = single screen, low page; 1 = single screen, high page; 2 = vertical; 3 = horizontal.
- R4: A write to offsets 0x504..0x507 loads `cpu_data` into program slot `cpu_addr[1:0]`.
- R5: A write to offsets 0x510..0x517 loads `cpu_data` into pattern slot `cpu_addr[2:0]`.
- R6: Program translation works as follows:
  - `cpu_addr[14:13]` picks the slot.
  - The bank is masked by (`cfg_prg_units` − 1), keeping its low 8 bits.
  - `prg_rom_addr` = {masked bank, `cpu_addr[12:0]`}.
- R7: When `vid_addr` < 0x2000 and `cfg_chr_ram` = 0:
  - `vid_addr[12:10]` picks the pattern slot.
  - The bank is masked by (`cfg_chr_units` − 1).
  - `pat_addr` = {masked bank, `vid_addr[9:0]`}.
  - `pat_rom_sel` = 1 and `pat_ram_sel` = 0.
- R8: When `vid_addr` < 0x2000 and `cfg_chr_ram` = 1:
  - `pat_ram_sel` = 1 and `pat_rom_sel` = 0.
  - `pat_addr` = `vid_addr[12:0]`, zero-extended.
  - The pattern bank registers have no effect.
- R9: When `vid_addr` ≥ 0x2000, both selects are 0 and `pat_addr` is 0.
- R10: Writes to other offsets in the window change no register and no output. A cycle with `cpu_wr` low changes no register, whatever the address and data.
- R11: A register write takes effect on the rising edge where `cpu_wr` is high. Translation during that cycle still uses the old bank, and the next cycle uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU address: write decode, and program translation on bits 14:0 |
| cpu_data | input | 8 | CPU write data |
| vid_addr | input | 14 | Video bus address |
| cfg_prg_units | input | 9 | Program-ROM size in 8 KB units |
| cfg_chr_units | input | 9 | Pattern-ROM size in 1 KB units |
| cfg_chr_ram | input | 1 | Pattern memory is RAM |
| cfg_mirror_init | input | 2 | Mirroring mode before the first mirroring write |
| prg_rom_addr | output | 21 | Translated program-ROM address |
| pat_addr | output | 18 | Pattern-ROM address, or raw pattern-RAM address |
| pat_rom_sel | output | 1 | Pattern ROM is addressed this cycle |
| pat_ram_sel | output | 1 | Pattern RAM is addressed this cycle |
| mirror_mode | output | 2 | Nametable mirroring mode |

## Verification
A pattern-bank write and a video fetch through the same slot can fall in the same cycle. The bench parks `vid_addr` in the slot being rewritten and raises `cpu_wr` for one cycle. It requires the old translated address before the capturing edge and the new one right after it. Aliased window addresses, out-of-window addresses and writes with the strobe low are mixed in. The register contents are then read back through translation to confirm that nothing moved.

// File: rtl/cbx_pkg.sv
package cbx_pkg;
   // Mirroring encodings
   typedef enum logic [1:0] {
      MIR_ONE_LO = 2'd0,
      MIR_ONE_HI = 2'd1,
      MIR_VERT   = 2'd2,
      MIR_HORZ   = 2'd3
   } mirror_e;

   localparam int OFS_W      = 11;        // decoded window offset width
   localparam int PRG_SLOTS  = 4;         // 8 KB slots in 32 KB window
   localparam int CHR_SLOTS  = 8;         // 1 KB slots in 8 KB pattern space
   localparam int PRG_PAGE_W = 13;
   localparam int CHR_PAGE_W = 10;

   // Offset groups, already shifted by the bits that index inside them
   localparam logic [OFS_W-2:0] MIR_GRP = 10'h17F; // 0x2FE..0x2FF
   localparam logic [OFS_W-3:0] PRG_GRP = 9'h141;  // 0x504..0x507
   localparam logic [OFS_W-4:0] CHR_GRP = 8'hA2;   // 0x510..0x517

   // Power-on program bank: first two slots low, last two at the top
   function automatic int prg_reset_bank(int slot, int w);
      return (slot < 2) ? slot : ((1 << w) - (PRG_SLOTS - slot));
   endfunction
endpackage

// File: rtl/cbx_regfile.sv
module cbx_regfile
   import cbx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CPU_AW     = 16,
   parameter int PRG_BANK_W = 8,
   parameter int CHR_BANK_W = 8,
   parameter logic [CPU_AW-1:0] EXP_FIRST = 16'h4020,
   parameter logic [CPU_AW-1:0] EXP_LAST  = 16'h5FFF
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_en,
   input  logic [CPU_AW-1:0]                     wr_addr,
   input  logic [DATA_W-1:0]                     wr_data,
   input  logic [1:0]                            mirror_init,
   output logic [PRG_SLOTS-1:0][PRG_BANK_W-1:0]  prg_bank,
   output logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0]  chr_bank,
   output logic [1:0]                            mirror
);
   logic             in_win;
   logic [OFS_W-1:0] ofs;
   logic             prg_hit, chr_hit, mir_hit;
   logic             mir_set;
   logic [1:0]       mir_q;

   assign in_win  = (wr_addr >= EXP_FIRST) && (wr_addr <= EXP_LAST);
   assign ofs     = wr_addr[OFS_W-1:0];
   assign prg_hit = wr_en && in_win && (ofs[OFS_W-1:2] == PRG_GRP);
   assign chr_hit = wr_en && in_win && (ofs[OFS_W-1:3] == CHR_GRP);
   assign mir_hit = wr_en && in_win && (ofs[OFS_W-1:1] == MIR_GRP);

   for (genvar i = 0; i < PRG_SLOTS; i++) begin : g_prg
      localparam logic [PRG_BANK_W-1:0] RST_V =
         PRG_BANK_W'(prg_reset_bank(i, PRG_BANK_W));
      logic [PRG_BANK_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          q <= RST_V;
         else if (prg_hit && ofs[1:0] == 2'(i)) q <= wr_data[PRG_BANK_W-1:0];
      end
      assign prg_bank[i] = q;

      // R4
      prg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (prg_hit && ofs[1:0] == 2'(i)) |=> (prg_bank[i] == $past(wr_data[PRG_BANK_W-1:0])));
   end

   for (genvar j = 0; j < CHR_SLOTS; j++) begin : g_chr
      logic [CHR_BANK_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          q <= '0;
         else if (chr_hit && ofs[2:0] == 3'(j)) q <= wr_data[CHR_BANK_W-1:0];
      end
      assign chr_bank[j] = q;

      // R5
      chr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (chr_hit && ofs[2:0] == 3'(j)) |=> (chr_bank[j] == $past(wr_data[CHR_BANK_W-1:0])));
   end

   // Mirroring: configuration value shows until software writes one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mir_set <= 1'b0;
         mir_q   <= MIR_ONE_LO;
      end else if (mir_hit) begin
         mir_set <= 1'b1;
         mir_q   <= {ofs[0], wr_data[4]};
      end
   end
   assign mirror = mir_set ? mir_q : mirror_init;

   // R3
   mirror_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mir_hit |=> (mirror == {$past(wr_addr[0]), $past(wr_data[4])}));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(prg_bank) && $stable(chr_bank) && $stable(mir_q) && $stable(mir_set)));

   // R1
   outside_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_win |=> ($stable(prg_bank) && $stable(chr_bank) && $stable(mir_q)));
endmodule

// File: rtl/cbx_prg_xlat.sv
module cbx_prg_xlat
   import cbx_pkg::*;
#(
   parameter int PRG_BANK_W = 8,
   localparam int ROM_AW    = PRG_BANK_W + PRG_PAGE_W
) (
   input  logic [PRG_SLOTS-1:0][PRG_BANK_W-1:0] prg_bank,
   input  logic [PRG_BANK_W:0]                  units,
   input  logic [PRG_PAGE_W+1:0]                addr,
   output logic [ROM_AW-1:0]                    rom_addr
);
   logic [PRG_BANK_W:0]   mask_full;
   logic [PRG_BANK_W-1:0] bank;

   assign mask_full = units - 1'b1;
   assign bank      = prg_bank[addr[PRG_PAGE_W+1:PRG_PAGE_W]] & mask_full[PRG_BANK_W-1:0];
   assign rom_addr  = {bank, addr[PRG_PAGE_W-1:0]};
endmodule

// File: rtl/cbx_chr_xlat.sv
module cbx_chr_xlat
   import cbx_pkg::*;
#(
   parameter int CHR_BANK_W = 8,
   parameter int VID_AW     = 14,
   localparam int PAT_AW    = CHR_BANK_W + CHR_PAGE_W
) (
   input  logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0] chr_bank,
   input  logic [CHR_BANK_W:0]                  units,
   input  logic                                 use_ram,
   input  logic [VID_AW-1:0]                    vid_addr,
   output logic [PAT_AW-1:0]                    pat_addr,
   output logic                                 rom_sel,
   output logic                                 ram_sel
);
   logic                  pattern_area;
   logic [CHR_BANK_W:0]   mask_full;
   logic [CHR_BANK_W-1:0] bank;

   assign pattern_area = (vid_addr[VID_AW-1:CHR_PAGE_W+3] == '0);
   assign mask_full    = units - 1'b1;
   assign bank         = chr_bank[vid_addr[CHR_PAGE_W+2:CHR_PAGE_W]] & mask_full[CHR_BANK_W-1:0];

   always_comb begin
      rom_sel  = pattern_area && !use_ram;
      ram_sel  = pattern_area && use_ram;
      pat_addr = '0;
      if (rom_sel)      pat_addr = {bank, vid_addr[CHR_PAGE_W-1:0]};
      else if (ram_sel) pat_addr = PAT_AW'(vid_addr[CHR_PAGE_W+2:0]);
   end
endmodule

// File: rtl/cart_bank_xlat.sv
module cart_bank_xlat
   import cbx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CPU_AW     = 16,
   parameter int VID_AW     = 14,
   parameter int PRG_BANK_W = 8,
   parameter int CHR_BANK_W = 8,
   parameter logic [CPU_AW-1:0] EXP_FIRST = 16'h4020,
   parameter logic [CPU_AW-1:0] EXP_LAST  = 16'h5FFF,
   localparam int PRG_AW    = PRG_BANK_W + PRG_PAGE_W,
   localparam int PAT_AW    = CHR_BANK_W + CHR_PAGE_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cpu_wr,
   input  logic [CPU_AW-1:0]     cpu_addr,
   input  logic [DATA_W-1:0]     cpu_data,
   input  logic [VID_AW-1:0]     vid_addr,
   input  logic [PRG_BANK_W:0]   cfg_prg_units,
   input  logic [CHR_BANK_W:0]   cfg_chr_units,
   input  logic                  cfg_chr_ram,
   input  logic [1:0]            cfg_mirror_init,
   output logic [PRG_AW-1:0]     prg_rom_addr,
   output logic [PAT_AW-1:0]     pat_addr,
   output logic                  pat_rom_sel,
   output logic                  pat_ram_sel,
   output logic [1:0]            mirror_mode
);
   // Elaboration-time parameter checks
   if (PRG_BANK_W < 2 || PRG_BANK_W > DATA_W) begin : g_bad_prg_w
      $error("PRG_BANK_W must be 2..DATA_W");
   end
   if (CHR_BANK_W < 3 || CHR_BANK_W > DATA_W) begin : g_bad_chr_w
      $error("CHR_BANK_W must be 3..DATA_W");
   end
   if (DATA_W < 5) begin : g_bad_data_w
      $error("DATA_W must carry the mirroring bit");
   end
   if (CPU_AW < OFS_W || VID_AW < CHR_PAGE_W + 4) begin : g_bad_aw
      $error("address widths too narrow");
   end

   logic [PRG_SLOTS-1:0][PRG_BANK_W-1:0] prg_bank;
   logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0] chr_bank;

   cbx_regfile #(
      .DATA_W(DATA_W), .CPU_AW(CPU_AW),
      .PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W),
      .EXP_FIRST(EXP_FIRST), .EXP_LAST(EXP_LAST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cpu_wr), .wr_addr(cpu_addr), .wr_data(cpu_data),
      .mirror_init(cfg_mirror_init),
      .prg_bank(prg_bank), .chr_bank(chr_bank), .mirror(mirror_mode)
   );

   cbx_prg_xlat #(.PRG_BANK_W(PRG_BANK_W)) u_prg (
      .prg_bank(prg_bank), .units(cfg_prg_units),
      .addr(cpu_addr[PRG_PAGE_W+1:0]), .rom_addr(prg_rom_addr)
   );

   cbx_chr_xlat #(.CHR_BANK_W(CHR_BANK_W), .VID_AW(VID_AW)) u_chr (
      .chr_bank(chr_bank), .units(cfg_chr_units), .use_ram(cfg_chr_ram),
      .vid_addr(vid_addr), .pat_addr(pat_addr),
      .rom_sel(pat_rom_sel), .ram_sel(pat_ram_sel)
   );

   // R8
   ram_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_chr_ram && vid_addr < VID_AW'(16'h2000)) |-> (pat_ram_sel && !pat_rom_sel));

   // R9
   sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pat_rom_sel, pat_ram_sel}));

   // R9
   above_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vid_addr >= VID_AW'(16'h2000)) |-> (!pat_rom_sel && !pat_ram_sel && pat_addr == '0));

   // R11
   prg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(cpu_addr[PRG_PAGE_W+1:0]) && $stable(cfg_prg_units) && !$past(cpu_wr))
         |-> $stable(prg_rom_addr));
endmodule

// File: tb/cart_bank_xlat_bench.sv
`timescale 1ns/1ps
module cart_bank_xlat_bench;
   typedef struct {
      int          src;   // 0 prg,1 pat,2 mirror,3 ram_sel,4 rom_sel
      logic [31:0] exp;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_data = '0;
   logic [13:0] vid_addr = '0;
   logic [8:0]  cfg_prg_units = 9'd16;
   logic [8:0]  cfg_chr_units = 9'd32;
   logic        cfg_chr_ram = 1'b0;
   logic [1:0]  cfg_mirror_init = 2'd3;
   logic [20:0] prg_rom_addr;
   logic [17:0] pat_addr;
   logic        pat_rom_sel, pat_ram_sel;
   logic [1:0]  mirror_mode;

   item_t       sb[$];
   int          n_cmp = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   logic [7:0]  m_prg[4];
   logic [7:0]  m_chr[8];
   logic [1:0]  m_mir;

   always #10 clk = ~clk;   // 50 MHz

   cart_bank_xlat u_cart_bank_xlat (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
      .cpu_data(cpu_data), .vid_addr(vid_addr),
      .cfg_prg_units(cfg_prg_units), .cfg_chr_units(cfg_chr_units),
      .cfg_chr_ram(cfg_chr_ram), .cfg_mirror_init(cfg_mirror_init),
      .prg_rom_addr(prg_rom_addr), .pat_addr(pat_addr),
      .pat_rom_sel(pat_rom_sel), .pat_ram_sel(pat_ram_sel),
      .mirror_mode(mirror_mode)
   );

   // Monitor: compares queued expectations away from the active edge
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = sb.pop_front();
         case (it.src)
            0: act = 32'(prg_rom_addr);
            1: act = 32'(pat_addr);
            2: act = 32'(mirror_mode);
            3: act = 32'(pat_ram_sel);
            default: act = 32'(pat_rom_sel);
         endcase
         n_cmp++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s src=%0d actual=%h expected=%h", it.tag, it.src, act, it.exp);
         end
      end
   end

   function automatic logic [31:0] exp_prg(logic [14:0] a);
      logic [7:0] msk = 8'(cfg_prg_units - 9'd1);
      return 32'({m_prg[a[14:13]] & msk, a[12:0]});
   endfunction

   function automatic logic [31:0] exp_pat(logic [13:0] v);
      logic [7:0] msk = 8'(cfg_chr_units - 9'd1);
      if (v >= 14'h2000) return 32'd0;
      if (cfg_chr_ram)   return 32'(v[12:0]);
      return 32'({m_chr[v[12:10]] & msk, v[9:0]});
   endfunction

   task automatic push(int src, logic [31:0] e, string tag);
      item_t it;
      it.src = src; it.exp = e; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic model_write(logic [15:0] a, logic [7:0] d);
      logic [10:0] o = a[10:0];
      if (a >= 16'h4020 && a <= 16'h5FFF) begin
         if (o == 11'h2FE || o == 11'h2FF)          m_mir = {a[0], d[4]};
         else if (o >= 11'h504 && o <= 11'h507)     m_prg[o[1:0]] = d;
         else if (o >= 11'h510 && o <= 11'h517)     m_chr[o[2:0]] = d;
      end
   endtask

   // Driver: one bus cycle with the strobe given; optional overlap check
   task automatic bus_write(logic [15:0] a, logic [7:0] d, bit strobe,
                            bit chk_old, string tag);
      @(posedge clk); #1;
      cpu_addr = a; cpu_data = d; cpu_wr = strobe;
      if (chk_old) push(1, exp_pat(vid_addr), tag);
      @(negedge clk);
      @(posedge clk); #1;
      cpu_wr = 1'b0;
      if (strobe) model_write(a, d);
   endtask

   task automatic probe_prg(logic [14:0] a, string tag);
      @(posedge clk); #1;
      cpu_addr = {1'b1, a};
      push(0, exp_prg(a), tag);
      @(negedge clk);
   endtask

   task automatic probe_pat(logic [13:0] v, string tag);
      logic [31:0] below = 32'(v < 14'h2000);
      @(posedge clk); #1;
      vid_addr = v;
      push(1, exp_pat(v), tag);
      push(3, below & 32'(cfg_chr_ram), tag);
      push(4, below & 32'(!cfg_chr_ram), tag);
      @(negedge clk);
   endtask

   task automatic probe_mir(string tag);
      @(posedge clk); #1;
      push(2, 32'(m_mir), tag);
      @(negedge clk);
   endtask

   task automatic probe_all(string tag);
      for (int s = 0; s < 4; s++) probe_prg(15'((s << 13) | 16'h0ABC), tag);
      for (int s = 0; s < 8; s++) probe_pat(14'((s << 10) | 16'h0123), tag);
      probe_mir(tag);
   endtask

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      m_prg[0] = 8'h00; m_prg[1] = 8'h01; m_prg[2] = 8'hFE; m_prg[3] = 8'hFF;
      for (int k = 0; k < 8; k++) m_chr[k] = 8'h00;
      m_mir = cfg_mirror_init;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R2 reset state
      probe_all("R2");

      // R4 program bank writes, R1 aliasing via low 11 bits
      bus_write(16'h4504, 8'h05, 1'b1, 1'b0, "R4");
      bus_write(16'h4505, 8'h13, 1'b1, 1'b0, "R4");
      bus_write(16'h5506, 8'h2A, 1'b1, 1'b0, "R1");
      bus_write(16'h4D07, 8'h07, 1'b1, 1'b0, "R1");
      for (int s = 0; s < 4; s++) probe_prg(15'((s << 13) | 16'h1FFF), "R6");

      // R5 pattern bank writes, R7 translation
      for (int s = 0; s < 8; s++)
         bus_write(16'(16'h5510 + s), 8'(8'h10 + 5 * s), 1'b1, 1'b0, "R5");
      for (int s = 0; s < 8; s++) probe_pat(14'((s << 10) | 16'h03FF), "R7");

      // R3 mirroring writes through all encodings
      bus_write(16'h42FE, 8'h10, 1'b1, 1'b0, "R3"); probe_mir("R3");
      bus_write(16'h42FF, 8'h00, 1'b1, 1'b0, "R3"); probe_mir("R3");
      bus_write(16'h42FF, 8'h10, 1'b1, 1'b0, "R3"); probe_mir("R3");
      bus_write(16'h4AFE, 8'hEF, 1'b1, 1'b0, "R3"); probe_mir("R3");

      // R10 unlisted offsets and strobe low; R1 out-of-window
      bus_write(16'h4508, 8'hFF, 1'b1, 1'b0, "R10");
      bus_write(16'h4503, 8'hFF, 1'b1, 1'b0, "R10");
      bus_write(16'h4518, 8'hFF, 1'b1, 1'b0, "R10");
      bus_write(16'h42FD, 8'hFF, 1'b1, 1'b0, "R10");
      bus_write(16'h4504, 8'hEE, 1'b0, 1'b0, "R10");
      bus_write(16'h42FF, 8'h10, 1'b0, 1'b0, "R10");
      bus_write(16'h6504, 8'hDD, 1'b1, 1'b0, "R1");
      bus_write(16'h3516, 8'hDD, 1'b1, 1'b0, "R1");
      probe_all("R10");

      // R11 write and fetch through the same slot in one cycle
      probe_pat(14'h1555, "R11");
      bus_write(16'h5515, 8'h1C, 1'b1, 1'b1, "R11");
      probe_pat(14'h1555, "R11");

      // R6 wider program mask
      cfg_prg_units = 9'h100;
      probe_prg(15'h2345, "R6");
      probe_prg(15'h6001, "R6");

      // R8 pattern RAM bypass, R9 above pattern space
      cfg_chr_ram = 1'b1;
      probe_pat(14'h1ABC, "R8");
      probe_pat(14'h0000, "R8");
      probe_pat(14'h2400, "R9");
      cfg_chr_ram = 1'b0;
      probe_pat(14'h3FFF, "R9");

      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule